// File: doc/BRIEF.md
# Frame-Clocked Register Access Port

This block gives a host controller access to a bank of eight 8-bit control registers over a single shared data line. The port has no fast serial clock. The controller pulls an active-low enable low and moves one bit on each rising edge of the 8 kHz frame sync. The frame sync and the other inputs are sampled in the system clock domain. Every access carries eleven bits, most significant first: a 3-bit register address and then an 8-bit value.

Reads are indirect. The controller writes the control register (address 7) with a request flag and a target address. The next access then becomes a read. The controller still clocks out three address slots, which the port ignores. After them the port takes over the line and shifts the named register out, most significant bit first. The request flag clears itself as soon as the read access starts. Two fields of the configuration register (address 4) are decoded onto dedicated outputs: the sample-format select and the power-down request.

Top module: `frame_reg_port`

## Requirements
- R1: After reset every register reads 0x00 except address 3, which holds 0x0F. The data-line output enable is low.
- R2: A bit is sampled on each rising edge of `fs_i` while `sden_ni` is low. The order is A2, A1, A0, D7 down to D0. The register named by A2..A0 takes D7..D0 only once the eleventh bit has been sampled.
- R3: If `sden_ni` is high at the frame-sync edge that would carry the eleventh bit, or at any earlier point, the access is abandoned and no register changes.
- R4: `sdata_i` is looked at only at frame-sync rising edges. Toggling it between edges has no effect on the value written.
- R5: When address 7 bit 3 is set as an access begins, that access is a read. After the third sampled slot the port raises `sdata_oe_o` and presents D7 on `sdata_o`. It presents one further bit after each later frame-sync edge, down to D0. It lowers the enable at the eleventh edge.
- R6: At the first sampled bit of a read access, bit 3 of address 7 returns to 0. Bits 2..0 of address 7 keep their value.
- R7: A read aimed at address 7 (bits 2..0 = 7) returns 0x00. Only addresses 0 to 6 can be read back.
- R8: `sdata_oe_o` is low in any cycle in which `sden_ni` is high, including partway through a read.
- R9: `fmt_o` equals bits 1..0 of address 4, and `pdn_o` equals bit 6 of address 4.
- R10: After eleven bits, further frame-sync edges with `sden_ni` still low are ignored until `sden_ni` has returned high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample all port inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame sync; one bit moves per rising edge |
| sden_ni | input | 1 | Access enable, active low |
| sdata_i | input | 1 | Data line as seen from the pad |
| sdata_o | output | 1 | Data driven toward the pad during reads |
| sdata_oe_o | output | 1 | Pad output enable for the data line |
| regs_o | output | 64 | All registers, address n at bits 8n+7..8n |
| fmt_o | output | 2 | Sample-format select from address 4 |
| pdn_o | output | 1 | Power-down request from address 4 |

## Verification
The sharpest collision is between the enable rising and the eleventh frame-sync edge. If both land in the same system clock cycle, the port must choose between committing and abandoning the access. The bench raises `fs_i` and `sden_ni` on the same edge after ten good bits and then checks that the target register is untouched. A second overlap is the enable dropping partway through a read while the port is driving. The bench confirms that the output enable falls in that same cycle and that the consumed request flag does not turn the next access into a read.

// File: rtl/frp_pkg.sv
package frp_pkg;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned CTRL_ADDR = 7;  // read-request register
  localparam int unsigned RD_FLAG   = 3;  // request flag bit in CTRL
  localparam int unsigned CFG_ADDR  = 4;  // configuration register
  localparam int unsigned FMT_LSB   = 0;
  localparam int unsigned PDN_BIT   = 6;

  typedef enum logic [1:0] {M_IDLE, M_WR, M_RD, M_DONE} mode_e;

  function automatic logic [31:0] reset_val(input int unsigned idx);
    return (idx == 3) ? 32'h0F : 32'h00;
  endfunction
endpackage

// File: rtl/frp_edge.sv
module frp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fs_i,
  output logic fs_rise_o
);
  logic fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fs_q <= 1'b0;
    else         fs_q <= fs_i;
  end

  assign fs_rise_o = fs_i & ~fs_q;
endmodule

// File: rtl/frp_regfile.sv
module frp_regfile import frp_pkg::*; #(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               clr_rd_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int unsigned RD_LIMIT = NREG - 1;  // top address is not readable

  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= DW'(reset_val(i));
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en_i && wr_addr_i == AW'(i))
          regs_q[i] <= wr_data_i;
        else if (clr_rd_i && i == CTRL_ADDR)
          regs_q[i][RD_FLAG] <= 1'b0;
      end
    end
  end

  assign rd_data_o = (int'(rd_addr_i) < RD_LIMIT) ? regs_q[rd_addr_i] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*DW +: DW] = regs_q[g];
  end

  // R2: a commit lands in the addressed register
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_q[$past(wr_addr_i)] == $past(wr_data_i));
  // R6: request flag drops after a read starts
  a_r6_flag_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rd_i |=> !regs_q[CTRL_ADDR][RD_FLAG]);
endmodule

// File: rtl/frp_shift.sv
module frp_shift import frp_pkg::*; #(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned FRAME_BITS = AW + DW,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fs_rise_i,
  input  logic          sden_ni,
  input  logic          sdata_i,
  input  logic          rd_pend_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          clr_rd_o,
  output logic          sdata_o,
  output logic          sdata_oe_o
);
  mode_e                 mode_q;
  logic [CW-1:0]         cnt_q;
  logic [FRAME_BITS-2:0] shift_q;
  logic [DW-1:0]         out_q;
  logic                  drive_q;
  logic                  sample;

  assign sample = fs_rise_i & ~sden_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      out_q   <= '0;
      drive_q <= 1'b0;
    end else if (sden_ni) begin
      mode_q  <= M_IDLE;
      cnt_q   <= '0;
      drive_q <= 1'b0;
    end else if (fs_rise_i) begin
      unique case (mode_q)
        M_IDLE: begin
          mode_q  <= rd_pend_i ? M_RD : M_WR;
          cnt_q   <= CW'(1);
          shift_q <= {shift_q[FRAME_BITS-3:0], sdata_i};
        end
        M_WR: begin
          cnt_q   <= cnt_q + 1'b1;
          shift_q <= {shift_q[FRAME_BITS-3:0], sdata_i};
          if (cnt_q == CW'(FRAME_BITS - 1)) mode_q <= M_DONE;
        end
        M_RD: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(AW - 1)) begin
            out_q   <= rd_data_i;
            drive_q <= 1'b1;
          end else if (cnt_q == CW'(FRAME_BITS - 1)) begin
            drive_q <= 1'b0;
            mode_q  <= M_DONE;
          end else if (drive_q) begin
            out_q <= {out_q[DW-2:0], 1'b0};
          end
        end
        default: ;  // M_DONE waits for enable release
      endcase
    end
  end

  assign wr_en_o    = sample && mode_q == M_WR && cnt_q == CW'(FRAME_BITS - 1);
  assign wr_addr_o  = shift_q[FRAME_BITS-2 -: AW];
  assign wr_data_o  = {shift_q[DW-2:0], sdata_i};
  assign clr_rd_o   = sample && mode_q == M_IDLE && rd_pend_i;
  assign sdata_o    = out_q[DW-1];
  assign sdata_oe_o = drive_q & ~sden_ni;

  // R3: enable high resets the access
  a_r3_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sden_ni |=> (cnt_q == '0 && !drive_q));
  // R4: position moves only on frame-sync edges
  a_r4_cnt_on_fs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fs_rise_i && !sden_ni) |=> $stable(cnt_q));
  // R5: drive window is the data slots only
  a_r5_drive_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> (cnt_q >= CW'(AW) && cnt_q <= CW'(FRAME_BITS - 1) && mode_q == M_RD));
  // R6: request is consumed before the port drives
  a_r6_flag_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_q) |-> !rd_pend_i);
endmodule

// File: rtl/frame_reg_port.sv
module frame_reg_port import frp_pkg::*; #(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fs_i,
  input  logic               sden_ni,
  input  logic               sdata_i,
  output logic               sdata_o,
  output logic               sdata_oe_o,
  output logic [NREG*DW-1:0] regs_o,
  output logic [1:0]         fmt_o,
  output logic               pdn_o
);
  logic          fs_rise;
  logic          wr_en, clr_rd;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic [DW-1:0] ctrl_reg, cfg_reg;

  assign ctrl_reg = regs_o[CTRL_ADDR*DW +: DW];
  assign cfg_reg  = regs_o[CFG_ADDR*DW +: DW];

  frp_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .fs_i(fs_i), .fs_rise_o(fs_rise)
  );

  frp_shift #(.AW(AW), .DW(DW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .fs_rise_i(fs_rise), .sden_ni(sden_ni),
    .sdata_i(sdata_i), .rd_pend_i(ctrl_reg[RD_FLAG]), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .clr_rd_o(clr_rd), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
  );

  frp_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .clr_rd_i(clr_rd), .rd_addr_i(ctrl_reg[AW-1:0]),
    .rd_data_o(rd_data), .regs_o(regs_o)
  );

  assign fmt_o = cfg_reg[FMT_LSB +: 2];
  assign pdn_o = cfg_reg[PDN_BIT];

  // R8: no drive while the enable is high
  a_r8_oe_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sden_ni |-> !sdata_oe_o);
  // R9: decoded fields follow a committed write to the config register
  a_r9_cfg_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == AW'(CFG_ADDR)) |=> (pdn_o == $past(wr_data[PDN_BIT])));
endmodule

// File: tb/frame_reg_port_bench.sv
module frame_reg_port_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fs_i = 1'b0, sden_ni = 1'b1, sdata_i = 1'b0;
  logic        sdata_o, sdata_oe_o, pdn_o;
  logic [63:0] regs_o;
  logic [1:0]  fmt_o;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  frame_reg_port u_frame_reg_port (
    .clk_i(clk), .rst_ni(rst_ni), .fs_i(fs_i), .sden_ni(sden_ni),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .regs_o(regs_o), .fmt_o(fmt_o), .pdn_o(pdn_o)
  );

  function automatic logic [7:0] rg(input int a);
    return regs_o[a*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk); sdata_i = b;
    @(negedge clk); fs_i = 1'b1;
    @(negedge clk); fs_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_frame(input logic [2:0] a, input logic [7:0] d);
    logic [10:0] f;
    f = {a, d};
    @(negedge clk); sden_ni = 1'b0;
    for (int i = 10; i >= 0; i--) pulse(f[i]);
    @(negedge clk); sden_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_frame(input string req, output logic [7:0] d);
    int bad;
    bad = 0;
    @(negedge clk); sden_ni = 1'b0;
    for (int i = 0; i < 3; i++) pulse(1'b1);
    for (int k = 7; k >= 0; k--) begin
      if (sdata_oe_o !== 1'b1) bad++;
      d[k] = sdata_o;
      pulse(1'b0);
    end
    chk({req, " oe held over data slots"}, bad, 0);
    chk({req, " oe low after last slot"}, sdata_oe_o, 1'b0);
    @(negedge clk); sden_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) chk("R1 reset value", rg(a), (a == 3) ? 8'h0F : 8'h00);
    chk("R1 oe low at reset", sdata_oe_o, 1'b0);
  endtask

  task automatic t_write;
    wr_frame(3'd1, 8'hA5);
    chk("R2 write addr1", rg(1), 8'hA5);
    wr_frame(3'd2, 8'h3C);
    chk("R2 write addr2", rg(2), 8'h3C);
    chk("R2 addr1 untouched", rg(1), 8'hA5);
    wr_frame(3'd3, 8'h80);
    chk("R2 write addr3", rg(3), 8'h80);
  endtask

  task automatic t_cfg;
    wr_frame(3'd4, 8'h41);
    chk("R9 fmt field", fmt_o, 2'b01);
    chk("R9 pdn bit", pdn_o, 1'b1);
    wr_frame(3'd4, 8'h02);
    chk("R9 fmt field 2", fmt_o, 2'b10);
    chk("R9 pdn cleared", pdn_o, 1'b0);
  endtask

  task automatic t_abort;
    logic [10:0] f;
    f = {3'd1, 8'hFF};
    @(negedge clk); sden_ni = 1'b0;
    for (int i = 10; i >= 4; i--) pulse(f[i]);
    @(negedge clk); sden_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 short access no change", rg(1), 8'hA5);
    // enable rises on the same edge as the eleventh bit
    @(negedge clk); sden_ni = 1'b0;
    for (int i = 10; i >= 1; i--) pulse(f[i]);
    @(negedge clk); sdata_i = f[0];
    @(negedge clk); fs_i = 1'b1; sden_ni = 1'b1;
    @(negedge clk); fs_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 coincident abort no change", rg(1), 8'hA5);
  endtask

  task automatic t_glitch;
    logic [10:0] f;
    f = {3'd5, 8'h96};
    @(negedge clk); sden_ni = 1'b0;
    for (int i = 10; i >= 0; i--) begin
      for (int j = 0; j < 3; j++) begin @(negedge clk); sdata_i = ~f[i]; @(negedge clk); sdata_i = f[i]; end
      @(negedge clk); sdata_i = f[i];
      @(negedge clk); fs_i = 1'b1;
      @(negedge clk); fs_i = 1'b0; sdata_i = ~f[i];
      @(negedge clk);
    end
    @(negedge clk); sden_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 glitches between edges ignored", rg(5), 8'h96);
  endtask

  task automatic t_read;
    logic [7:0] d;
    wr_frame(3'd7, 8'h09);
    chk("R6 request stored", rg(7), 8'h09);
    @(negedge clk); sden_ni = 1'b0;
    pulse(1'b0);
    chk("R6 flag cleared at first bit", rg(7), 8'h01);
    @(negedge clk); sden_ni = 1'b1;
    repeat (2) @(negedge clk);
    wr_frame(3'd7, 8'h0A);
    rd_frame("R5 read addr2", d);
    chk("R5 read data addr2", d, 8'h3C);
    chk("R6 flag clear, addr kept", rg(7), 8'h02);
    wr_frame(3'd7, 8'h0B);
    rd_frame("R5 read addr3", d);
    chk("R5 read data addr3", d, 8'h80);
  endtask

  task automatic t_read7;
    logic [7:0] d;
    wr_frame(3'd7, 8'h0F);
    rd_frame("R7 read addr7", d);
    chk("R7 addr7 returns zero", d, 8'h00);
  endtask

  task automatic t_oe_release;
    wr_frame(3'd7, 8'h09);
    @(negedge clk); sden_ni = 1'b0;
    for (int i = 0; i < 6; i++) pulse(1'b0);
    chk("R8 driving mid read", sdata_oe_o, 1'b1);
    @(negedge clk); sden_ni = 1'b1;
    #1;
    chk("R8 oe drops with enable", sdata_oe_o, 1'b0);
    repeat (2) @(negedge clk);
    wr_frame(3'd6, 8'h5A);
    chk("R8 next access is a write", rg(6), 8'h5A);
  endtask

  task automatic t_done;
    logic [21:0] f;
    f = {3'd0, 8'hC3, 3'd5, 8'h77};
    @(negedge clk); sden_ni = 1'b0;
    for (int i = 21; i >= 0; i--) pulse(f[i]);
    @(negedge clk); sden_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 first frame committed", rg(0), 8'hC3);
    chk("R10 trailing bits ignored", rg(5), 8'h96);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_cfg();
    t_abort();
    t_glitch();
    t_read();
    t_read7();
    t_oe_release();
    t_done();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule